// File: doc/BRIEF.md
# Prioritized Indexed Interrupt Controller

This block collects a parameterized set of system interrupt inputs (64 by default) and produces one host interrupt line. A 32-bit register bus with a single-cycle write strobe and a combinational read port configures it. Each input has its own sense setting: rising edge, falling edge, active-high level or active-low level. It also has a raw pending bit and an enable bit. Software can set or clear an enable, or clear a pending bit, by writing the input's number to an index register. It can also clear many bits at once by writing a 1 to each bit position of a 32-bit mask word.

Every input is assigned to a priority channel through a byte in a packed map, four inputs per word. A prioritized-index register returns the input number that currently wins arbitration among the inputs that are both enabled and pending, or a "none" flag. Two control words at the usual positions for nesting and hold control are kept as plain storage, so that driver code writing them keeps working. The host line needs a global enable and a host-side enable bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every pending and enable bit is 0, the global enable and both host enables are 0, the prioritized-index word (0x80) reads 0x8000_0000, and every input is configured as active-high level (polarity 1, type 0).
- R2: With type 0, an input whose synchronized level equals its polarity bit sets its pending bit on each cycle. A clear made while the level is still present therefore does not leave the bit at 0.
- R3: Polarity words start at 0xD00 and type words start at 0xD80, one bit per input and 32 inputs per word (input n is bit n%32 of word n/32). Type 1 with polarity 1 latches pending on a synchronized rising edge, and type 1 with polarity 0 latches it on a falling edge. Type 0 with polarity 0 is active-low level.
- R4: Writing input number n (bits 9:0) to 0x28 sets its enable bit, and writing it to 0x2C clears that bit. A number that is not below the input count changes nothing.
- R5: Writing input number n to 0x24 clears its pending bit.
- R6: Mask words at 0x280+4k (pending) and 0x380+4k (enable) read back the raw bits of inputs 32k..32k+31. Writing a 1 to a bit clears the matching bit, and writing a 0 to a bit leaves it unchanged.
- R7: Channel map words at 0x400+4k hold the channel of input 4k+j in byte j. After reset every byte is the highest channel number (7 with 8 channels).
- R8: The word at 0x80 holds the winning input number in bits 9:0. The winner is the enabled, pending input with the lowest channel number, and among inputs on that channel the lowest input number wins. When no enabled input is pending, bit 31 is 1 and bits 9:0 are 0.
- R9: Host enables are set by writing 0 or 1 to 0x34 and cleared by writing it to 0x38. Other values are ignored. The host enable bits read back at 0x1500. The host line is 1 exactly when the global enable (0x10, bit 0) is 1, host enable 1 is set, and some input is enabled and pending.
- R10: Words 0x04 and 0x0C store and read back any 32-bit value and have no other effect.
- R11: When a new event on an input and a write clearing that input's pending bit fall in the same cycle, the pending bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Asynchronous system interrupt inputs |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| host_irq | output | 1 | Host interrupt line, active high |

## Verification
A status-clear write and a new event on the same input can land in the same clock cycle. The bench provokes this by raising a rising-edge input exactly two clock edges ahead of a write to the status-index-clear register. That timing puts the synchronized edge detection and the clear on the same edge. The pending bit is read back afterwards and must still be set. The same overlap for level inputs is judged by clearing an input whose level is held active and checking that its pending bit reads 1 again.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IN = 64,
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              host_irq
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NWD    = (NUM_IN + 31) / 32;
  localparam int NMW    = (NUM_IN + 3) / 4;
  localparam int IDX_W  = 10;
  localparam logic [CH_W-1:0] CH_RST = CH_W'(NUM_CH - 1);
  localparam int A_CTL  = 'h004 >> 2, A_HCTL = 'h00C >> 2, A_GLB = 'h010 >> 2;
  localparam int A_SCLR = 'h024 >> 2, A_ESET = 'h028 >> 2, A_ECLR = 'h02C >> 2;
  localparam int A_HSET = 'h034 >> 2, A_HCLR = 'h038 >> 2, A_PRIO = 'h080 >> 2;
  localparam int B_SBM  = 'h280 >> 2, B_EBM  = 'h380 >> 2, B_MAP  = 'h400 >> 2;
  localparam int B_POL  = 'hD00 >> 2, B_TYP  = 'hD80 >> 2, A_HEN  = 'h1500 >> 2;

  logic [NUM_IN-1:0] sync1, sync2, prev;
  logic [NUM_IN-1:0] pol_q, typ_q, stat_q, en_q;
  logic [CH_W-1:0]   ch_q [NUM_IN];
  logic              glb_q;
  logic [1:0]        hen_q;
  logic [31:0]       ctl_q, hctl_q;

  logic [NUM_IN-1:0] det, pend, stat_clr, en_set, en_clr, win_oh;
  logic [NUM_IN-1:0] pol_wr, typ_wr, map_wr;
  logic [CH_W-1:0]   map_wd [NUM_IN];
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  int                wa, widx;

  assign wa   = int'(bus_addr[ADDR_W-1:2]);
  assign widx = int'(bus_wdata[IDX_W-1:0]);
  assign det  = (typ_q & ((pol_q & sync2 & ~prev) | (~pol_q & ~sync2 & prev)))
              | (~typ_q & ~(sync2 ^ pol_q));
  assign pend = stat_q & en_q;
  assign host_irq = glb_q & hen_q[1] & (|pend);

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      stat_clr[i] = bus_we && ((wa == A_SCLR && widx == i) ||
                    (wa == B_SBM + i / 32 && bus_wdata[i % 32]));
      en_set[i]   = bus_we && wa == A_ESET && widx == i;
      en_clr[i]   = bus_we && ((wa == A_ECLR && widx == i) ||
                    (wa == B_EBM + i / 32 && bus_wdata[i % 32]));
      pol_wr[i]   = bus_we && wa == B_POL + i / 32;
      typ_wr[i]   = bus_we && wa == B_TYP + i / 32;
      map_wr[i]   = bus_we && wa == B_MAP + i / 4;
      map_wd[i]   = bus_wdata[8 * (i % 4) +: CH_W];
    end
  end

  always_comb begin
    int best;
    best    = NUM_CH;
    found   = 1'b0;
    win_idx = '0;
    win_oh  = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (pend[i] && int'(ch_q[i]) < best) begin
        best    = int'(ch_q[i]);
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_oh  = '0;
        win_oh[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      glb_q  <= 1'b0;
      hen_q  <= '0;
      ctl_q  <= '0;
      hctl_q <= '0;
      for (int i = 0; i < NUM_IN; i++) ch_q[i] <= CH_RST;
    end else begin
      sync1  <= irq_in;
      sync2  <= sync1;
      prev   <= sync2;
      stat_q <= (stat_q & ~stat_clr) | det;
      en_q   <= (en_q & ~en_clr) | en_set;
      for (int i = 0; i < NUM_IN; i++) begin
        if (pol_wr[i]) pol_q[i] <= bus_wdata[i % 32];
        if (typ_wr[i]) typ_q[i] <= bus_wdata[i % 32];
        if (map_wr[i]) ch_q[i]  <= map_wd[i];
      end
      if (bus_we) begin
        if (wa == A_GLB)  glb_q  <= bus_wdata[0];
        if (wa == A_CTL)  ctl_q  <= bus_wdata;
        if (wa == A_HCTL) hctl_q <= bus_wdata;
        if (wa == A_HSET && widx < 2) hen_q[widx[0]] <= 1'b1;
        if (wa == A_HCLR && widx < 2) hen_q[widx[0]] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (wa == A_CTL)       bus_rdata = ctl_q;
    else if (wa == A_HCTL) bus_rdata = hctl_q;
    else if (wa == A_GLB)  bus_rdata = {31'd0, glb_q};
    else if (wa == A_HEN)  bus_rdata = {30'd0, hen_q};
    else if (wa == A_PRIO) bus_rdata = {~found, 21'd0, win_idx};
    else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (wa == B_SBM + i / 32) bus_rdata[i % 32] = stat_q[i];
        if (wa == B_EBM + i / 32) bus_rdata[i % 32] = en_q[i];
        if (wa == B_POL + i / 32) bus_rdata[i % 32] = pol_q[i];
        if (wa == B_TYP + i / 32) bus_rdata[i % 32] = typ_q[i];
        if (wa == B_MAP + i / 4)  bus_rdata[8 * (i % 4) +: CH_W] = ch_q[i];
      end
    end
  end

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set))); // R4
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((en_q & $past(en_clr)) == '0)); // R6
  AST_STAT_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr & ~det)) |=> ((stat_q & $past(stat_clr & ~det)) == '0)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|det) |=> ((stat_q & $past(det)) == $past(det))); // R11
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ($countones(win_oh & pend) == 1)); // R8
  AST_GLB_GATES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> !host_irq); // R9
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 40;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic          bus_we = 1'b0;
  logic [12:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          host_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int chmap [NI];
  bit [NI-1:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_IN(NI), .NUM_CH(NC), .ADDR_W(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 13'(a); bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 13'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic clear_all_status();
    wr('h280, '1); wr('h284, '1);
  endtask

  function automatic logic [31:0] word_of(bit [NI-1:0] v, int k);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (32 * k + b < NI) r[b] = v[32 * k + b];
    return r;
  endfunction

  function automatic logic [31:0] model_prio(bit [NI-1:0] p);
    int best = NC, w = -1;
    for (int i = 0; i < NI; i++)
      if (p[i] && chmap[i] < best) begin best = chmap[i]; w = i; end
    return (w < 0) ? 32'h8000_0000 : 32'(w);
  endfunction

  initial begin
    logic [31:0] d;
    bit [NI-1:0] pat;
    bit [NI-1:0] pats [4];
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;

    // R1 reset state
    rd('h80, d);  chk("R1 prio none", d, 32'h8000_0000);
    chk("R1 host_irq", 32'(host_irq), 0);
    rd('h380, d); chk("R1 enable w0", d, 0);
    rd('h284, d); chk("R1 status w1", d, 0);
    rd('hD04, d); chk("R1 polarity w1", d, 32'h0000_00FF);
    rd('hD80, d); chk("R1 type w0", d, 0);
    rd('h1500, d); chk("R1 host enables", d, 0);
    for (int k = 0; k < (NI + 3) / 4; k++) begin
      rd('h400 + 4 * k, d); chk("R7 map reset", d, 32'h0707_0707);
    end

    // R4 enable by index, sweep
    m_en = '0;
    for (int i = 0; i < NI; i++) begin wr('h28, i); m_en[i] = 1; end
    for (int i = 1; i < NI; i += 2) begin wr('h2C, i); m_en[i] = 0; end
    wr('h28, NI); wr('h2C, NI + 1);
    rd('h380, d); chk("R4 enable w0", d, word_of(m_en, 0));
    rd('h384, d); chk("R4 enable w1", d, word_of(m_en, 1));
    // R6 enable mask clear
    wr('h380, 32'h0000_00F0); m_en[7:4] = '0;
    rd('h380, d); chk("R6 enable mask clear", d, word_of(m_en, 0));

    // R2 level inputs latch, R6 mask clear of status
    pat = 40'hA5_1234_C3E1;
    irq_in = pat; wait_cyc(4);
    rd('h280, d); chk("R2 level latch w0", d, word_of(pat, 0));
    rd('h284, d); chk("R2 level latch w1", d, word_of(pat, 1));
    irq_in = '0; wait_cyc(4);
    rd('h280, d); chk("R2 latched after drop", d, word_of(pat, 0));
    wr('h280, 32'h0000_FFFF);
    rd('h280, d); chk("R6 status mask clear", d, word_of(pat, 0) & 32'hFFFF_0000);
    clear_all_status();
    rd('h284, d); chk("R6 status w1 clear", d, 0);
    // R2 clear while level held
    irq_in[9] = 1'b1; wait_cyc(4);
    wr('h24, 9); wait_cyc(1);
    rd('h280, d); chk("R2 re-set while active", d, 32'h0000_0200);
    // R5 clear by index after drop
    irq_in[9] = 1'b0; wait_cyc(4);
    wr('h24, 9);
    rd('h280, d); chk("R5 index clear", d, 0);

    // R3 edge and low-level modes
    wr('hD00, ~32'h0000_0060);
    wr('hD80, 32'h0000_0028);
    wait_cyc(4); clear_all_status(); wait_cyc(2);
    rd('h280, d); chk("R3 active-low idle", d, 32'h0000_0040);
    irq_in[3] = 1'b1; irq_in[5] = 1'b1; wait_cyc(4);
    rd('h280, d); chk("R3 rising edge", d, 32'h0000_0048);
    irq_in[3] = 1'b0; irq_in[5] = 1'b0; wait_cyc(4);
    rd('h280, d); chk("R3 falling edge", d, 32'h0000_0068);

    // R11 edge event coincides with index clear
    wr('hD80, 32'h0000_0004);
    wr('hD00, '1);
    wait_cyc(4); clear_all_status();
    @(negedge clk); irq_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr('h24, 2);
    rd('h280, d); chk("R11 event beats clear", d, 32'h0000_0004);
    irq_in[2] = 1'b0;
    wr('hD80, 0); wait_cyc(4); clear_all_status();

    // R7 map programming and readback
    for (int i = 0; i < NI; i++) chmap[i] = (i * 5 + 3) % NC;
    for (int k = 0; k < (NI + 3) / 4; k++) begin
      logic [31:0] w = '0;
      for (int j = 0; j < 4; j++) w[8 * j +: 8] = 8'(chmap[4 * k + j]);
      wr('h400 + 4 * k, w);
      rd('h400 + 4 * k, d); chk("R7 map readback", d, w);
    end

    // R8 arbitration sweep: retire winners one by one
    pats[0] = 40'hFF_FFFF_FFFF;
    pats[1] = 40'h80_0001_0010;
    pats[2] = 40'h12_4924_9249;
    pats[3] = 40'h00_0000_0000;
    foreach (pats[p]) begin
      for (int i = 0; i < NI; i++) wr('h28, i);
      m_en = '1;
      irq_in = pats[p]; wait_cyc(4); irq_in = '0; wait_cyc(4);
      for (int s = 0; s <= NI; s++) begin
        logic [31:0] e;
        e = model_prio(pats[p] & m_en);
        rd('h80, d); chk("R8 prioritized index", d, e);
        if (e[31]) break;
        wr('h2C, e); m_en[e[5:0]] = 1'b0;
      end
      clear_all_status();
    end

    // R9 host line gating
    wr('h28, 11); irq_in[11] = 1'b1; wait_cyc(4);
    chk("R9 global off", 32'(host_irq), 0);
    wr('h10, 1);
    chk("R9 host enable off", 32'(host_irq), 0);
    wr('h34, 1); #1;
    chk("R9 line on", 32'(host_irq), 1);
    wr('h34, 5);
    rd('h1500, d); chk("R9 bad index ignored", d, 2);
    wr('h2C, 11); #1;
    chk("R9 no enabled pending", 32'(host_irq), 0);
    wr('h28, 11); wr('h38, 1); #1;
    chk("R9 host enable cleared", 32'(host_irq), 0);
    rd('h1500, d); chk("R9 host enables readback", d, 0);
    irq_in = '0;

    // R10 storage words
    wr('h04, 32'h1234_ABCD); wr('h0C, 32'hDEAD_0F0F);
    rd('h04, d); chk("R10 ctrl word", d, 32'h1234_ABCD);
    rd('h0C, d); chk("R10 host ctrl word", d, 32'hDEAD_0F0F);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule